// File: doc/BRIEF.md
# Alternating Bit Pair Detector

This block watches a serial stream from a sensor, one bit per clock, and reports whether the two most recent bits differ. A single flag output is high when the newest bit and the one before it differ, and low when they match, whether both are zeros or both are ones. It is a Moore machine: the flag is decoded from the stored state only, so it never follows the serial input directly and settles one clock after the bit that changes it.

Two D flip-flops hold one of four states, each recording a two-bit history. The states are: last pair "1 then 0", last pair "0 then 1", two ones, and two zeros. The codes are a fixed Gray-style assignment, chosen so that the flag is the XNOR of the two state bits and the next-state equations reduce to an inverter and a wire. A synchronous reset loads the "1 then 0" history, so the flag reads high before any real bit has arrived. The first real bit is then compared against an implied previous 0.

Top module: `altdet_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, the machine loads its reset history whatever `din` is, and `flag` reads 1 after that edge.
- R2: After two consecutive sampled bits that differ (01 or 10, with no reset between them), `flag` is 1.
- R3: After two consecutive sampled zeros, `flag` is 0.
- R4: After two consecutive sampled ones, `flag` is 0.
- R5: `flag` changes only at a rising clock edge and one cycle after the bit that causes the change. A change on `din` between edges has no effect on `flag` until the next edge samples it.
- R6: The first bit sampled after reset is compared against an implied previous 0: a first bit of 0 gives `flag` 0, and a first bit of 1 gives `flag` 1.
- R7: Asserting reset in the middle of a stream discards the stored history, and the next bit is again treated as the first bit after reset (R6).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk  | input  | 1 | Clock; `din` is sampled on its rising edge |
| rst  | input  | 1 | Synchronous active-high reset |
| din  | input  | 1 | Serial sensor bit, one per clock |
| flag | output | 1 | 1 when the last two sampled bits differ, decoded from state |

## Verification
The bench drives runs of equal bits in both polarities, strict alternation, and mixed patterns. A next-state table with a swapped arc would stick in one equal state or drop the self-loop, and the flag would go wrong within one or two bits. It checks the first bit after reset in both polarities, including after a reset in mid-stream. A design that reset into the wrong state or kept stale history would report the wrong flag on exactly that bit. It also toggles `din` between clock edges and confirms that `flag` holds, which catches an output decoded from the input in Mealy style. Holding `din` at 1 through reset catches a reset that lets the input through.

// File: rtl/altdet_pkg.sv
package altdet_pkg;

  localparam int ST_W = 2;

  // Gray-style assignment: flag = XNOR of the two bits.
  typedef enum logic [ST_W-1:0] {
    ST_G01 = 2'b00,  // last 0, before it 1
    ST_G11 = 2'b01,  // two ones
    ST_G10 = 2'b11,  // last 1, before it 0
    ST_G00 = 2'b10   // two zeros
  } alt_state_t;

  localparam alt_state_t ST_RESET = ST_G01;

endpackage

// File: rtl/altdet_state_reg.sv
module altdet_state_reg
  import altdet_pkg::*;
#(
  parameter alt_state_t RESET_VAL = ST_RESET
) (
  input  logic       clk,
  input  logic       rst,
  input  alt_state_t nxt,
  output alt_state_t cur
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur <= RESET_VAL;
    end else begin
      cur <= nxt;
    end
  end

endmodule

// File: rtl/altdet_next_state.sv
module altdet_next_state
  import altdet_pkg::*;
(
  input  alt_state_t cur,
  input  logic       bit_in,
  output alt_state_t nxt
);

  // Each state has exactly one successor per input value.
  always_comb begin
    unique case (cur)
      ST_G01, ST_G00: nxt = bit_in ? ST_G10 : ST_G00;
      ST_G11, ST_G10: nxt = bit_in ? ST_G11 : ST_G01;
      default:        nxt = ST_RESET;
    endcase
  end

endmodule

// File: rtl/altdet_flag_decode.sv
module altdet_flag_decode
  import altdet_pkg::*;
(
  input  alt_state_t cur,
  output logic       alt
);

  logic [ST_W-1:0] code;

  always_comb begin
    code = cur;
    alt  = ~(code[1] ^ code[0]);
  end

endmodule

// File: rtl/altdet_top.sv
module altdet_top
  import altdet_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic flag
);

  alt_state_t cur_state;
  alt_state_t nxt_state;

  altdet_state_reg #(
    .RESET_VAL(ST_RESET)
  ) u_sreg (
    .clk (clk),
    .rst (rst),
    .nxt (nxt_state),
    .cur (cur_state)
  );

  altdet_next_state u_nsl (
    .cur    (cur_state),
    .bit_in (din),
    .nxt    (nxt_state)
  );

  altdet_flag_decode u_ofl (
    .cur (cur_state),
    .alt (flag)
  );

endmodule

// File: rtl/altdet_chk.sv
module altdet_chk (
  input logic       clk,
  input logic       rst,
  input logic       din,
  input logic       flag,
  input logic [1:0] state
);

  // R1: reset loads the alternating history whatever din is.
  a_r1_reset_alt: assert property (@(posedge clk)
    rst |=> (flag && state == 2'b00));

  // R2: two differing bits give flag 1.
  a_r2_differ: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (din != $past(din))) |=> flag);

  // R3 and R4: two equal bits give flag 0.
  a_r3_r4_equal: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (din == $past(din))) |=> !flag);

  // R5: flag moves only with the state register.
  a_r5_moore: assert property (@(posedge clk) disable iff (rst)
    $stable(state) |-> $stable(flag));

  // R6 and R7: first bit after reset is compared against an implied 0.
  a_r6_first_bit: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |=> (flag == $past(din)));

endmodule

bind altdet_top altdet_chk u_chk (
  .clk   (clk),
  .rst   (rst),
  .din   (din),
  .flag  (flag),
  .state (cur_state)
);

// File: tb/sim_altdet_top.sv
module sim_altdet_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Behavioural history: index 0 is the newest bit.
  int hist[$];
  bit first_after_reset;

  always #10 clk = ~clk;

  altdet_top u0 (
    .clk  (clk),
    .rst  (rst),
    .din  (din),
    .flag (flag)
  );

  task automatic check(input logic exp, input string req);
    checks++;
    if (flag !== exp) begin
      errors++;
      $display("FAIL %s: flag=%b expected=%b at %0t", req, flag, exp, $time);
    end
  endtask

  task automatic do_reset(input logic din_val);
    @(negedge clk);
    rst = 1'b1;
    din = din_val;
    @(posedge clk);
    hist = {0, 1};
    first_after_reset = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(1'b1, "R1");
  endtask

  task automatic push(input logic b);
    string req;
    logic exp;
    din = b;
    @(posedge clk);
    hist.push_front(int'(b));
    if (hist.size() > 2) void'(hist.pop_back());
    exp = (hist[0] != hist[1]);
    if (first_after_reset) req = "R6/R7";
    else if (exp) req = "R2";
    else if (hist[0] == 0) req = "R3";
    else req = "R4";
    first_after_reset = 1'b0;
    @(negedge clk);
    check(exp, req);
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset with din held high
    do_reset(1'b1);
    repeat (2) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(1'b1, "R1");
    rst = 1'b0;
    hist = {0, 1};
    first_after_reset = 1'b1;

    // R6: first bit 0
    push(1'b0);
    // R3: run of zeros
    push(1'b0);
    push(1'b0);
    // R2: alternation
    for (int i = 0; i < 6; i++) push(logic'(i[0] == 0));
    // R4: run of ones
    push(1'b1);
    push(1'b1);
    push(1'b1);

    // R5: toggle din between edges, flag must hold
    begin
      logic held;
      held = flag;
      din = ~din;
      #3;
      checks++;
      if (flag !== held) begin
        errors++;
        $display("FAIL R5: flag=%b expected=%b after mid-cycle din change", flag, held);
      end
      din = ~din;
      #3;
      check(held, "R5");
    end
    @(negedge clk);

    // R7: mid-stream reset, first bit 1
    do_reset(1'b0);
    push(1'b1);
    push(1'b0);
    // R7: mid-stream reset after ones, first bit 0
    push(1'b1);
    push(1'b1);
    do_reset(1'b1);
    push(1'b0);

    // mixed pattern
    for (int i = 0; i < 40; i++) push(logic'(((i * 7) % 5) > 2));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule